// File: doc/BRIEF.md
# Board control register file behind a serial management slave

This block is a board-management register file that answers management frames as a slave. The management master drives a slow serial clock and a data line into the block. The block returns read data on a separate output line, with an output enable, so the pad logic can merge the two lines onto a shared wire. An active-low enable input gates the whole slave. The serial clock and data are oversampled in the block's own system clock domain through a two-flop synchronizer.

Each frame carries a 5-bit device field and a 5-bit register field, both sent MSB first. The block joins them into one flat 10-bit register address: the device field gives the upper five bits and the register field gives the lower five. The register space holds the following:
- read-only identification words;
- a writable mode word and a mode-applied word that is read back from pins;
- an active-low switch bank;
- writable power, peripheral and indicator registers;
- a self-clearing reset register that emits a fixed-length system reset pulse.

A small slow region at the top of the map models storage that needs a repeated read. Its data is valid only when the read repeats the previous read address.

The frame path is a plain serial protocol with no valid/ready stage. A read fetches its word once the header is complete and shifts it out at the master's pace. A write commits in the system cycle after its last data bit is seen, so the block has no back-pressure to signal.

Top module: `brd_ctrl_mdio`

## Requirements
- R1: The register address of a frame is {device field[4:0], register field[4:0]}. A write to 0x02E (device 1, register 0x0E) does not reach the indicator register at 0x00E.
- R2: A frame is recognised only after at least 32 consecutive ones sampled on MDC rising edges, followed by start bits 0,1. A frame preceded by only 31 ones is ignored.
- R3: In a read (opcode 1,0), the output enable stays low during the first turnaround bit. The block then drives 0 in the second turnaround bit and 16 data bits MSB first. Each bit changes only after an MDC falling edge, and the output enable drops after the falling edge that follows the last data bit.
- R4: A write (opcode 0,1) requires turnaround bits 1,0, followed by 16 data bits MSB first. A write with any other turnaround pair is dropped. Opcodes 0,0 and 1,1 are ignored.
- R5: Addresses 0x000 and 0x001 read back the low and high halves of PROD_ID, and 0x002 and 0x003 the low and high halves of VER_ID. Writes to these addresses are ignored.
- R6: The mode words at 0x004 (low) and 0x005 (high), power at 0x00B, peripheral words at 0x00C (low) and 0x00D (high) and indicators at 0x00E are read/write. They appear on mode_set_o, power_o, peri_o and led_o.
- R7: 0x006 and 0x007 read mode_app_i[15:0] and mode_app_i[31:16]. 0x008 reads the switch pins as driven, active low, in bits 11:0, with bits 15:12 zero.
- R8: In the slow region 0x300 to 0x303, the registers are PCB version, SoC version and serial low/high. A read returns the true value only when its address equals the previous read address. Otherwise it returns the most recent true value fetched from the region, which is 0x0000 after reset.
- R9: Writing a word with bit 0 set to 0x00A raises sys_rst_o for exactly RST_PULSE system clocks. After that, 0x00A reads 0x0000.
- R10: Reads of unmapped addresses return 0x0000, and writes to them change nothing.
- R11: While mdio_en_n is high, frames are ignored and mdio_oe stays low. Raising it in the middle of a write frame cancels that write.
- R12: After reset, mdio_oe, mdio_do and sys_rst_o are low and every writable register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management serial clock from the master |
| mdio_di | input | 1 | Serial data from the master |
| mdio_en_n | input | 1 | Active-low slave enable |
| mdio_do | output | 1 | Serial read data to the master |
| mdio_oe | output | 1 | High while mdio_do is driven |
| dip_n_i | input | 12 | Switch bank pins, active low |
| mode_app_i | input | 32 | Mode-applied word read back from pins |
| mode_set_o | output | 32 | Writable mode word {0x005, 0x004} |
| power_o | output | 16 | Power configuration register |
| peri_o | output | 32 | Peripheral configuration {0x00D, 0x00C} |
| led_o | output | 16 | Indicator register |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with a preamble length of 32, a reset pulse of 16 clocks, a slow region based at 0x300 and distinct nonzero identification constants. These constants let every read-only word be told apart from the stale slow-region value and from zero. The bench MDC half period is 6 system clocks, which leaves room after the three-register synchroniser path for each output bit to settle before the master samples. This in turn brings the falling-edge timing of the turnaround bit and of the release checkable. With these values the stale-then-fresh order of the slow region can be walked across all four of its addresses. The same holds for an interleaved read of a fast address, the exact pulse length and the 31-versus-32 preamble boundary.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;
  localparam int FLD_W  = 5;
  localparam int ADDR_W = 2 * FLD_W;
  localparam int DATA_W = 16;
  localparam int HDR_W  = 2 + ADDR_W;

  localparam logic [ADDR_W-1:0] A_PROD_LO = 10'h000;
  localparam logic [ADDR_W-1:0] A_PROD_HI = 10'h001;
  localparam logic [ADDR_W-1:0] A_VER_LO  = 10'h002;
  localparam logic [ADDR_W-1:0] A_VER_HI  = 10'h003;
  localparam logic [ADDR_W-1:0] A_MODE_LO = 10'h004;
  localparam logic [ADDR_W-1:0] A_MODE_HI = 10'h005;
  localparam logic [ADDR_W-1:0] A_APP_LO  = 10'h006;
  localparam logic [ADDR_W-1:0] A_APP_HI  = 10'h007;
  localparam logic [ADDR_W-1:0] A_SWITCH  = 10'h008;
  localparam logic [ADDR_W-1:0] A_RESET   = 10'h00A;
  localparam logic [ADDR_W-1:0] A_POWER   = 10'h00B;
  localparam logic [ADDR_W-1:0] A_PERI_LO = 10'h00C;
  localparam logic [ADDR_W-1:0] A_PERI_HI = 10'h00D;
  localparam logic [ADDR_W-1:0] A_LED     = 10'h00E;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    FS_HUNT,
    FS_START,
    FS_HDR,
    FS_TA_RD,
    FS_RD,
    FS_TA_WR,
    FS_WR
  } frm_state_e;
endpackage

// File: rtl/brd_sync_bus.sv
module brd_sync_bus #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/brd_mdio_frame.sv
module brd_mdio_frame
  import brd_ctrl_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_s,
  input  logic              di_s,
  input  logic              en_s,
  output logic              req_rd,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mdio_do,
  output logic              mdio_oe
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int CW  = (PCW > 4) ? PCW : 4;
  localparam logic [CW-1:0] PRE_MAX  = CW'(PRE_LEN);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_W - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(DATA_W - 1);

  frm_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic              mdc_prev_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [DATA_W-2:0] wsh_q;
  logic [DATA_W-1:0] rsh_q;
  logic              rise, fall;
  logic [HDR_W-1:0]  hdr_nxt;
  logic [1:0]        op_nxt;

  assign rise    = mdc_s & ~mdc_prev_q;
  assign fall    = ~mdc_s & mdc_prev_q;
  assign hdr_nxt = {hdr_q, di_s};
  assign op_nxt  = hdr_nxt[HDR_W-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FS_HUNT;
      cnt_q      <= '0;
      mdc_prev_q <= 1'b0;
      hdr_q      <= '0;
      wsh_q      <= '0;
      rsh_q      <= '0;
      req_rd     <= 1'b0;
      req_wr     <= 1'b0;
      req_addr   <= '0;
      req_wdata  <= '0;
      mdio_do    <= 1'b0;
      mdio_oe    <= 1'b0;
    end else begin
      mdc_prev_q <= mdc_s;
      req_rd     <= 1'b0;
      req_wr     <= 1'b0;
      if (!en_s) begin
        state_q <= FS_HUNT;
        cnt_q   <= '0;
        mdio_oe <= 1'b0;
        mdio_do <= 1'b0;
      end else begin
        if (req_rd) rsh_q <= rd_data;
        if (rise) begin
          unique case (state_q)
            FS_HUNT: begin
              if (di_s) begin
                if (cnt_q != PRE_MAX) cnt_q <= cnt_q + 1'b1;
              end else if (cnt_q == PRE_MAX) begin
                state_q <= FS_START;
                cnt_q   <= '0;
              end else begin
                cnt_q <= '0;
              end
            end
            FS_START: begin
              cnt_q   <= '0;
              state_q <= di_s ? FS_HDR : FS_HUNT;
            end
            FS_HDR: begin
              hdr_q <= hdr_nxt[HDR_W-2:0];
              if (cnt_q == HDR_LAST) begin
                cnt_q    <= '0;
                req_addr <= hdr_nxt[ADDR_W-1:0];
                if (op_nxt == OP_RD) begin
                  state_q <= FS_TA_RD;
                  req_rd  <= 1'b1;
                end else if (op_nxt == OP_WR) begin
                  state_q <= FS_TA_WR;
                end else begin
                  state_q <= FS_HUNT;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            FS_TA_RD: begin
              if (cnt_q == '0) cnt_q <= 1'b1;
              else begin
                cnt_q   <= '0;
                state_q <= FS_RD;
              end
            end
            FS_RD: begin
              if (cnt_q == DAT_LAST) begin
                cnt_q   <= '0;
                state_q <= FS_HUNT;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            FS_TA_WR: begin
              if (cnt_q == '0) begin
                if (di_s) cnt_q <= 1'b1;
                else state_q <= FS_HUNT;
              end else begin
                cnt_q   <= '0;
                state_q <= di_s ? FS_HUNT : FS_WR;
              end
            end
            FS_WR: begin
              wsh_q <= {wsh_q[DATA_W-3:0], di_s};
              if (cnt_q == DAT_LAST) begin
                cnt_q     <= '0;
                state_q   <= FS_HUNT;
                req_wr    <= 1'b1;
                req_wdata <= {wsh_q, di_s};
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: begin
              state_q <= FS_HUNT;
              cnt_q   <= '0;
            end
          endcase
        end
        if (fall) begin
          if (state_q == FS_TA_RD && cnt_q != '0) begin
            mdio_oe <= 1'b1;
            mdio_do <= 1'b0;
          end else if (state_q == FS_RD) begin
            mdio_oe <= 1'b1;
            mdio_do <= rsh_q[DATA_W-1];
            rsh_q   <= {rsh_q[DATA_W-2:0], 1'b0};
          end else begin
            mdio_oe <= 1'b0;
            mdio_do <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/brd_reg_bank.sv
module brd_reg_bank
  import brd_ctrl_pkg::*;
#(
  parameter logic [31:0]       PROD_ID   = 32'h0,
  parameter logic [31:0]       VER_ID    = 32'h0,
  parameter logic [15:0]       PCB_VER   = 16'h0,
  parameter logic [15:0]       SOC_VER   = 16'h0,
  parameter logic [31:0]       SERIAL    = 32'h0,
  parameter logic [ADDR_W-1:0] SLOW_BASE = 10'h300,
  parameter int                RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [11:0]       dip_n_i,
  input  logic [31:0]       mode_app_i,
  output logic [31:0]       mode_set_o,
  output logic [15:0]       power_o,
  output logic [31:0]       peri_o,
  output logic [15:0]       led_o,
  output logic              sys_rst_o
);
  localparam int RCW = $clog2(RST_PULSE + 1);
  localparam logic [RCW-1:0] RST_LOAD = RCW'(RST_PULSE);

  logic [DATA_W-1:0] mode_lo_q, mode_hi_q, power_q, peri_lo_q, peri_hi_q, led_q;
  logic [RCW-1:0]    rst_cnt_q;
  logic [ADDR_W-1:0] prev_addr_q;
  logic [DATA_W-1:0] stale_q;
  logic [DATA_W-1:0] fresh;
  logic [11:0]       dip_s;
  logic              in_slow;

  brd_sync_bus #(.W(12), .RST_VAL(12'hFFF)) u_dip_sync (
    .clk(clk), .rst_n(rst_n), .async_i(dip_n_i), .sync_o(dip_s)
  );

  assign in_slow   = (addr[ADDR_W-1:2] == SLOW_BASE[ADDR_W-1:2]);
  assign sys_rst_o = (rst_cnt_q != '0);

  always_comb begin
    fresh = '0;
    if (in_slow) begin
      unique case (addr[1:0])
        2'd0: fresh = PCB_VER;
        2'd1: fresh = SOC_VER;
        2'd2: fresh = SERIAL[15:0];
        default: fresh = SERIAL[31:16];
      endcase
    end else begin
      case (addr)
        A_PROD_LO: fresh = PROD_ID[15:0];
        A_PROD_HI: fresh = PROD_ID[31:16];
        A_VER_LO:  fresh = VER_ID[15:0];
        A_VER_HI:  fresh = VER_ID[31:16];
        A_MODE_LO: fresh = mode_lo_q;
        A_MODE_HI: fresh = mode_hi_q;
        A_APP_LO:  fresh = mode_app_i[15:0];
        A_APP_HI:  fresh = mode_app_i[31:16];
        A_SWITCH:  fresh = {4'b0000, dip_s};
        A_RESET:   fresh = {{(DATA_W-1){1'b0}}, sys_rst_o};
        A_POWER:   fresh = power_q;
        A_PERI_LO: fresh = peri_lo_q;
        A_PERI_HI: fresh = peri_hi_q;
        A_LED:     fresh = led_q;
        default:   fresh = '0;
      endcase
    end
  end

  assign rdata = (in_slow && addr != prev_addr_q) ? stale_q : fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo_q   <= '0;
      mode_hi_q   <= '0;
      power_q     <= '0;
      peri_lo_q   <= '0;
      peri_hi_q   <= '0;
      led_q       <= '0;
      rst_cnt_q   <= '0;
      prev_addr_q <= '1;
      stale_q     <= '0;
    end else begin
      if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
      if (rd_en) begin
        prev_addr_q <= addr;
        if (in_slow) stale_q <= fresh;
      end
      if (wr_en) begin
        case (addr)
          A_MODE_LO: mode_lo_q <= wdata;
          A_MODE_HI: mode_hi_q <= wdata;
          A_POWER:   power_q   <= wdata;
          A_PERI_LO: peri_lo_q <= wdata;
          A_PERI_HI: peri_hi_q <= wdata;
          A_LED:     led_q     <= wdata;
          A_RESET:   if (wdata[0] && rst_cnt_q == '0) rst_cnt_q <= RST_LOAD;
          default:   ;
        endcase
      end
    end
  end

  assign mode_set_o = {mode_hi_q, mode_lo_q};
  assign power_o    = power_q;
  assign peri_o     = {peri_hi_q, peri_lo_q};
  assign led_o      = led_q;
endmodule

// File: rtl/brd_ctrl_mdio.sv
module brd_ctrl_mdio
  import brd_ctrl_pkg::*;
#(
  parameter int                PRE_LEN   = 32,
  parameter int                RST_PULSE = 16,
  parameter logic [31:0]       PROD_ID   = 32'h5A17_0001,
  parameter logic [31:0]       VER_ID    = 32'h0002_0011,
  parameter logic [15:0]       PCB_VER   = 16'h0101,
  parameter logic [15:0]       SOC_VER   = 16'h0200,
  parameter logic [31:0]       SERIAL    = 32'h0000_0001,
  parameter logic [ADDR_W-1:0] SLOW_BASE = 10'h300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc_i,
  input  logic        mdio_di,
  input  logic        mdio_en_n,
  output logic        mdio_do,
  output logic        mdio_oe,
  input  logic [11:0] dip_n_i,
  input  logic [31:0] mode_app_i,
  output logic [31:0] mode_set_o,
  output logic [15:0] power_o,
  output logic [31:0] peri_o,
  output logic [15:0] led_o,
  output logic        sys_rst_o
);
  logic [2:0]        pin_s;
  logic              fr_rd, fr_wr;
  logic [ADDR_W-1:0] fr_addr;
  logic [DATA_W-1:0] fr_wdata, bank_rdata;

  brd_sync_bus #(.W(3), .RST_VAL(3'b110)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({mdio_en_n, mdio_di, mdc_i}),
    .sync_o(pin_s)
  );

  brd_mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .mdc_s(pin_s[0]), .di_s(pin_s[1]), .en_s(~pin_s[2]),
    .req_rd(fr_rd), .req_wr(fr_wr), .req_addr(fr_addr), .req_wdata(fr_wdata),
    .rd_data(bank_rdata), .mdio_do(mdio_do), .mdio_oe(mdio_oe)
  );

  brd_reg_bank #(
    .PROD_ID(PROD_ID), .VER_ID(VER_ID), .PCB_VER(PCB_VER), .SOC_VER(SOC_VER),
    .SERIAL(SERIAL), .SLOW_BASE(SLOW_BASE), .RST_PULSE(RST_PULSE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_en(fr_rd), .wr_en(fr_wr), .addr(fr_addr), .wdata(fr_wdata), .rdata(bank_rdata),
    .dip_n_i(dip_n_i), .mode_app_i(mode_app_i),
    .mode_set_o(mode_set_o), .power_o(power_o), .peri_o(peri_o), .led_o(led_o),
    .sys_rst_o(sys_rst_o)
  );
endmodule

// File: rtl/brd_ctrl_mdio_chk.sv
module brd_ctrl_mdio_chk #(
  parameter int RST_PULSE = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc_i,
  input logic       mdio_en_n,
  input logic       mdio_do,
  input logic       mdio_oe,
  input logic       sys_rst_o,
  input logic       wr_req,
  input logic       rd_req,
  input logic [9:0] wr_addr,
  input logic [15:0] wr_data
);
  localparam int HCW = $clog2(RST_PULSE + 2);
  logic [HCW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt_q <= '0;
    else if (sys_rst_o) begin
      if (hi_cnt_q != '1) hi_cnt_q <= hi_cnt_q + 1'b1;
    end else hi_cnt_q <= '0;
  end

  // R9: pulse never longer than RST_PULSE
  assert_rst_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt_q <= HCW'(RST_PULSE));

  // R9: pulse ends exactly after RST_PULSE cycles
  assert_rst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> hi_cnt_q == HCW'(RST_PULSE));

  // R9: pulse starts only from a reset-register write with bit 0 set
  assert_rst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(wr_req && wr_addr == 10'h00A && wr_data[0]));

  // R11: disabled slave keeps its driver off
  assert_en_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_en_n && $past(mdio_en_n, 1) && $past(mdio_en_n, 2) && $past(mdio_en_n, 3))
      |-> !mdio_oe);

  // R3: the driver turns on only after a falling MDC edge
  assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdc_i);

  // R3: undriven output is held low
  assert_do_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> !mdio_do);

  // R4: a frame is either a read or a write, never both
  assert_one_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
endmodule

bind brd_ctrl_mdio brd_ctrl_mdio_chk #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_en_n(mdio_en_n),
  .mdio_do(mdio_do), .mdio_oe(mdio_oe), .sys_rst_o(sys_rst_o),
  .wr_req(fr_wr), .rd_req(fr_rd), .wr_addr(fr_addr), .wr_data(fr_wdata)
);

// File: tb/brd_ctrl_mdio_test.sv
`timescale 1ns/1ps
module brd_ctrl_mdio_test;
  localparam int H = 6;
  localparam logic [31:0] P_PROD = 32'hB0A7_0C01;
  localparam logic [31:0] P_VER  = 32'h0003_0107;
  localparam logic [15:0] P_PCB  = 16'h0102;
  localparam logic [15:0] P_SOC  = 16'h0300;
  localparam logic [31:0] P_SN   = 32'h0001_E240;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mdc = 1'b0, di = 1'b1, en_n = 1'b0;
  logic mdio_do, mdio_oe, sys_rst_o;
  logic [11:0] dip_n = 12'h5A3;
  logic [31:0] mode_app = 32'h1234_5678;
  logic [31:0] mode_set_o, peri_o;
  logic [15:0] power_o, led_o;
  int checks = 0, fails = 0, rst_hi = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (sys_rst_o) rst_hi <= rst_hi + 1;

  brd_ctrl_mdio #(.PRE_LEN(32), .RST_PULSE(16), .PROD_ID(P_PROD), .VER_ID(P_VER),
    .PCB_VER(P_PCB), .SOC_VER(P_SOC), .SERIAL(P_SN), .SLOW_BASE(10'h300)) uut (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_di(di), .mdio_en_n(en_n),
    .mdio_do(mdio_do), .mdio_oe(mdio_oe), .dip_n_i(dip_n), .mode_app_i(mode_app),
    .mode_set_o(mode_set_o), .power_o(power_o), .peri_o(peri_o), .led_o(led_o),
    .sys_rst_o(sys_rst_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; mdc = 1'b0; wait_n(H);
    mdc = 1'b1; wait_n(H);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [9:0] a, input int npre);
    for (int i = 0; i < npre; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 9; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic mdio_write(input logic [9:0] a, input logic [15:0] d,
                            input logic [1:0] op = 2'b01, input logic [1:0] ta = 2'b10,
                            input int npre = 32);
    send_hdr(op, a, npre);
    send_bit(ta[1]); send_bit(ta[0]);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic mdio_read(input logic [9:0] a, output logic [15:0] d,
                           output logic ta_ok, output logic oe_ta1,
                           output logic oe_all, output logic oe_any, output logic oe_after);
    send_hdr(2'b10, a, 32);
    di = 1'b1; d = '0;
    mdc = 1'b0; wait_n(H); oe_ta1 = mdio_oe; mdc = 1'b1; wait_n(H);
    mdc = 1'b0; wait_n(H); ta_ok = mdio_oe & ~mdio_do;
    oe_any = mdio_oe | oe_ta1; oe_all = 1'b1;
    mdc = 1'b1; wait_n(H);
    for (int i = 0; i < 16; i++) begin
      mdc = 1'b0; wait_n(H);
      d = {d[14:0], mdio_do};
      oe_all &= mdio_oe; oe_any |= mdio_oe;
      mdc = 1'b1; wait_n(H);
    end
    di = 1'b0; mdc = 1'b0; wait_n(H); oe_after = mdio_oe;
    mdc = 1'b1; wait_n(H); di = 1'b1;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    logic t, o1, oa, oy, of;
    mdio_read(a, d, t, o1, oa, oy, of);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R12 oe after reset", mdio_oe, 0);
    chk("R12 do after reset", mdio_do, 0);
    chk("R12 sys_rst after reset", sys_rst_o, 0);
    chk("R12 mode_set after reset", mode_set_o, 0);
    chk("R12 led after reset", led_o, 0);
    rd(10'h00B, v); chk("R12 power reads zero", v, 0);
  endtask

  task automatic t_slow;
    logic [15:0] v;
    rd(10'h300, v); chk("R8 first 0x300 stale", v, 16'h0000);
    rd(10'h300, v); chk("R8 repeat 0x300", v, P_PCB);
    rd(10'h301, v); chk("R8 first 0x301 stale", v, P_PCB);
    rd(10'h301, v); chk("R8 repeat 0x301", v, P_SOC);
    rd(10'h302, v); chk("R8 first 0x302 stale", v, P_SOC);
    rd(10'h302, v); chk("R8 repeat 0x302", v, P_SN[15:0]);
    rd(10'h303, v); chk("R8 first 0x303 stale", v, P_SN[15:0]);
    rd(10'h303, v); chk("R8 repeat 0x303", v, P_SN[31:16]);
    rd(10'h000, v); chk("R5 prod low", v, P_PROD[15:0]);
    rd(10'h302, v); chk("R8 after fast read stale", v, P_SN[31:16]);
  endtask

  task automatic t_read_timing;
    logic [15:0] v; logic t, o1, oa, oy, of;
    mdio_read(10'h001, v, t, o1, oa, oy, of);
    chk("R3 oe low in first TA", o1, 0);
    chk("R3 second TA driven 0", t, 1);
    chk("R3 oe through data", oa, 1);
    chk("R3 released after data", of, 0);
    chk("R5 prod high", v, P_PROD[31:16]);
    rd(10'h002, v); chk("R5 ver low", v, P_VER[15:0]);
    rd(10'h003, v); chk("R5 ver high", v, P_VER[31:16]);
    mdio_write(10'h000, 16'hFFFF);
    rd(10'h000, v); chk("R5 prod write ignored", v, P_PROD[15:0]);
  endtask

  task automatic t_rw;
    logic [15:0] v;
    mdio_write(10'h004, 16'hA55A); mdio_write(10'h005, 16'h0F0F);
    mdio_write(10'h00B, 16'h00C3); mdio_write(10'h00C, 16'h1111);
    mdio_write(10'h00D, 16'h2222); mdio_write(10'h00E, 16'h8001);
    rd(10'h004, v); chk("R6 mode low", v, 16'hA55A);
    rd(10'h005, v); chk("R6 mode high", v, 16'h0F0F);
    rd(10'h00B, v); chk("R6 power", v, 16'h00C3);
    rd(10'h00C, v); chk("R6 peri low", v, 16'h1111);
    rd(10'h00D, v); chk("R6 peri high", v, 16'h2222);
    rd(10'h00E, v); chk("R6 led", v, 16'h8001);
    chk("R6 mode_set_o", mode_set_o, 32'h0F0F_A55A);
    chk("R6 power_o", power_o, 16'h00C3);
    chk("R6 peri_o", peri_o, 32'h2222_1111);
    chk("R6 led_o", led_o, 16'h8001);
  endtask

  task automatic t_inputs;
    logic [15:0] v;
    rd(10'h006, v); chk("R7 applied low", v, 16'h5678);
    rd(10'h007, v); chk("R7 applied high", v, 16'h1234);
    rd(10'h008, v); chk("R7 switches", v, 16'h05A3);
    dip_n = 12'hFFE;
    rd(10'h008, v); chk("R7 switches changed", v, 16'h0FFE);
  endtask

  task automatic t_addr;
    logic [15:0] v;
    mdio_write(10'h02E, 16'h7777);
    chk("R1 device field separates 0x02E", led_o, 16'h8001);
    rd(10'h02E, v); chk("R10 0x02E reads zero", v, 0);
    mdio_write(10'h010, 16'h1234);
    rd(10'h010, v); chk("R10 unmapped 0x010", v, 0);
    rd(10'h009, v); chk("R10 unmapped 0x009", v, 0);
    rd(10'h304, v); chk("R10 unmapped 0x304", v, 0);
    mdio_write(10'h300, 16'hDEAD);
    rd(10'h300, v); rd(10'h300, v); chk("R10 slow region not writable", v, P_PCB);
  endtask

  task automatic t_frames;
    mdio_write(10'h00E, 16'h0042);
    chk("R4 write committed", led_o, 16'h0042);
    mdio_write(10'h00E, 16'h1111, 2'b01, 2'b10, 31);
    chk("R2 31-one preamble ignored", led_o, 16'h0042);
    mdio_write(10'h00E, 16'h2222, 2'b01, 2'b11);
    chk("R4 bad turnaround dropped", led_o, 16'h0042);
    mdio_write(10'h00E, 16'h3333, 2'b11);
    chk("R4 opcode 11 ignored", led_o, 16'h0042);
    mdio_write(10'h00E, 16'h4444, 2'b00);
    chk("R4 opcode 00 ignored", led_o, 16'h0042);
    mdio_write(10'h00E, 16'h0055);
    chk("R2 32-one preamble accepted", led_o, 16'h0055);
  endtask

  task automatic t_enable;
    logic [15:0] v; logic t, o1, oa, oy, of;
    en_n = 1'b1;
    mdio_write(10'h00E, 16'h6666);
    chk("R11 disabled write ignored", led_o, 16'h0055);
    mdio_read(10'h00E, v, t, o1, oa, oy, of);
    chk("R11 disabled read never drives", oy, 0);
    en_n = 1'b0; wait_n(4);
    send_hdr(2'b01, 10'h00E, 32);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    en_n = 1'b1; send_bit(1'b0); send_bit(1'b1);
    en_n = 1'b0;
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    wait_n(4);
    chk("R11 write cancelled mid frame", led_o, 16'h0055);
  endtask

  task automatic t_sysrst;
    logic [15:0] v;
    rst_hi = 0;
    mdio_write(10'h00A, 16'h0001);
    chk("R9 sys_rst raised", sys_rst_o, 1);
    wait_n(40);
    chk("R9 pulse length", rst_hi, 16);
    chk("R9 sys_rst dropped", sys_rst_o, 0);
    rd(10'h00A, v); chk("R9 reset bit self-cleared", v, 0);
    mdio_write(10'h00A, 16'h0002); wait_n(40);
    chk("R9 bit 0 clear gives no pulse", rst_hi, 16);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(5);
    t_reset();
    t_slow();
    t_read_timing();
    t_rw();
    t_inputs();
    t_addr();
    t_frames();
    t_enable();
    t_sysrst();
    finish_run();
  end
endmodule